// File: doc/BRIEF.md
# Interrupt Controller Command Sequencer

This block is the byte-wide register front end of an eight-input priority interrupt controller. A host writes and reads through a port with two addresses. Writes to address 0 carry either an initialization start word or one of two operation commands. Bits 4 and 3 of the byte choose between these three decoders. Writes to address 1 carry either the next word of the initialization sequence or a new interrupt mask. The block turns these accesses into mode flags, a mask, a vector base and one-cycle command strobes. A separate priority resolver, which is not part of this block, acts on these outputs.

Initialization is a short sequence of steps. After the start word, the next address-1 write supplies the vector base. A cascade word follows unless single mode was chosen. A mode word follows if the start word asked for one. The read path returns the mask at address 1. At address 0 it returns the poll result, the in-service vector or the request vector. End-of-interrupt, rotate and set-priority commands leave as registered strobes, high for exactly one cycle, together with a 3-bit level.

Top module: `intc_cmd_seq`

## Requirements
- R1: After reset, maskReg, vecBase and every flag and strobe output are 0, and initBusy is 0.
- R2: An address-0 write with bit 4 set starts initialization. It latches singleMode from bit 1 and the mode-word-needed flag from bit 0, and sets initBusy. It clears maskReg, specMask, readIsr, pollPend, autoEoi, nestedMode and rotateOnAeoi. It pulses initClear for one cycle.
- R3: The first address-1 write after the start word loads vecBase with the byte's bits 2:0 forced to 0.
- R4: After the vector base, the cascade step comes next unless singleMode is set. After the base (in single mode) or after the cascade word, the mode-word step comes next if it was requested; otherwise initBusy drops. Address-1 writes made during initialization leave maskReg unchanged.
- R5: The mode word sets nestedMode from bit 4 and autoEoi from bit 1, and ends initialization.
- R6: An address-1 write outside initialization loads maskReg. An address-1 read returns maskReg.
- R7: An address-0 write with bit 4 clear and bit 3 set is a read-control command. When its bit 1 is set, bit 0 picks the source of address-0 reads: 1 selects svcVec and 0 selects reqVec. When bit 1 is clear, the selection is unchanged.
- R8: In a read-control command, bit 6 set loads specMask from bit 5. Bit 6 clear leaves specMask unchanged.
- R9: Bit 2 of a read-control command sets pollPend. While pollPend is set, an address-0 read returns pollData and clears pollPend. The cycle after that read, pollAck is high for one cycle.
- R10: An address-0 write with bits 4 and 3 clear is a priority command, with the code in bits 7:5 and the level in bits 2:0. Codes 1, 3, 5 and 7 pulse eoiStb. Codes 3 and 7 also set eoiSpecific. Codes 5 and 7 also pulse rotateStb. cmdLevel carries the level.
- R11: Priority command code 6 pulses setPrioStb with cmdLevel, and does not pulse eoiStb.
- R12: Codes 0 and 4 load rotateOnAeoi from bit 7, so 0 clears it and 4 sets it. Code 2 raises no strobe and changes no flag.
- R13: Bit 3 of the start word (level-triggered request) sets initError. initError holds until the next start word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Write strobe, one byte per cycle |
| rdEn | input | 1 | Read strobe |
| addr | input | 1 | Register address (0 or 1) |
| wrData | input | 8 | Write byte |
| rdData | output | 8 | Read byte (combinational) |
| reqVec | input | 8 | Pending-request vector from the resolver |
| svcVec | input | 8 | In-service vector from the resolver |
| pollData | input | 8 | Poll result from the resolver |
| maskReg | output | 8 | Interrupt mask |
| vecBase | output | 8 | Vector base, low 3 bits zero |
| singleMode | output | 1 | No cascade partner |
| autoEoi | output | 1 | Automatic end-of-interrupt mode |
| nestedMode | output | 1 | Special fully nested mode |
| specMask | output | 1 | Special mask mode |
| readIsr | output | 1 | Address-0 reads return svcVec |
| pollPend | output | 1 | Poll read pending |
| rotateOnAeoi | output | 1 | Rotate on automatic end-of-interrupt |
| initBusy | output | 1 | Initialization sequence in progress |
| initError | output | 1 | Unsupported level-triggered request seen |
| initClear | output | 1 | One-cycle pulse: clear in-service state and rotation |
| pollAck | output | 1 | One-cycle pulse: poll read acts as acknowledge |
| eoiStb | output | 1 | One-cycle end-of-interrupt strobe |
| eoiSpecific | output | 1 | The EOI names cmdLevel |
| rotateStb | output | 1 | One-cycle rotate-with-EOI strobe |
| setPrioStb | output | 1 | One-cycle set-priority strobe |
| cmdLevel | output | 3 | Level carried by the command |

## Verification
The bench runs every branch of the initialization sequence. A sequencer that ignored single mode would take the next mask write as a cascade word. One that ignored the mode-word flag would leave initBusy high, or would load the mask with the mode byte. The bench checks that bit 1 of the read-control command gates the read-select update and that bit 6 gates the special-mask update. A missing gate shows up as a changed read source or a changed specMask. The bench tests that a poll clears after a single read, so a sticky poll would return pollData a second time. It sends every priority command code and checks each strobe for a single cycle. This catches swapped codes, a level on the wrong bits and strobes that stay high.

// File: rtl/intc_cmd_seq_pkg.sv
package intc_cmd_seq_pkg;
  localparam int DATA_W = 8;
  localparam int LVL_W  = 3;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_BASE = 2'd1,
    SEQ_CASC = 2'd2,
    SEQ_MODE = 2'd3
  } seqState_t;

  typedef struct packed {
    logic initStart;
    logic loadBase;
    logic loadMode;
    logic loadMask;
    logic loadRdCtl;
    logic loadPrio;
    logic pollRead;
  } seqCmd_t;
endpackage

// File: rtl/intc_cmd_seq_ctrl.sv
module intc_cmd_seq_ctrl
  import intc_cmd_seq_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic          rdEn,
  input  logic          addr,
  input  logic [DW-1:0] wrData,
  input  logic          pollPend,
  output seqCmd_t       cmd,
  output logic          singleMode,
  output logic          initBusy,
  output logic          initError
);
  seqState_t state;
  logic      needMode;
  logic      wrLo, wrHi;

  assign wrLo = wrEn && !addr;
  assign wrHi = wrEn && addr;
  assign initBusy = (state != SEQ_IDLE);

  always_comb begin
    cmd           = '0;
    cmd.initStart = wrLo && wrData[4];
    cmd.loadRdCtl = wrLo && !wrData[4] && wrData[3];
    cmd.loadPrio  = wrLo && !wrData[4] && !wrData[3];
    cmd.loadBase  = wrHi && (state == SEQ_BASE);
    cmd.loadMode  = wrHi && (state == SEQ_MODE);
    cmd.loadMask  = wrHi && (state == SEQ_IDLE);
    cmd.pollRead  = rdEn && !addr && pollPend && !cmd.loadRdCtl;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= SEQ_IDLE;
      singleMode <= 1'b0;
      needMode   <= 1'b0;
      initError  <= 1'b0;
    end else if (cmd.initStart) begin
      state      <= SEQ_BASE;
      singleMode <= wrData[1];
      needMode   <= wrData[0];
      initError  <= wrData[3];
    end else if (wrHi) begin
      unique case (state)
        SEQ_BASE: begin
          if (!singleMode)   state <= SEQ_CASC;
          else if (needMode) state <= SEQ_MODE;
          else               state <= SEQ_IDLE;
        end
        SEQ_CASC: state <= needMode ? SEQ_MODE : SEQ_IDLE;
        SEQ_MODE: state <= SEQ_IDLE;
        default:  state <= state;
      endcase
    end
  end
endmodule

// File: rtl/intc_cmd_seq_regs.sv
module intc_cmd_seq_regs
  import intc_cmd_seq_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int LW = LVL_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  seqCmd_t       cmd,
  input  logic          addr,
  input  logic [DW-1:0] wrData,
  input  logic [DW-1:0] reqVec,
  input  logic [DW-1:0] svcVec,
  input  logic [DW-1:0] pollData,
  output logic [DW-1:0] rdData,
  output logic [DW-1:0] maskReg,
  output logic [DW-1:0] vecBase,
  output logic          autoEoi,
  output logic          nestedMode,
  output logic          specMask,
  output logic          readIsr,
  output logic          pollPend,
  output logic          rotateOnAeoi,
  output logic          initClear,
  output logic          pollAck,
  output logic          eoiStb,
  output logic          eoiSpecific,
  output logic          rotateStb,
  output logic          setPrioStb,
  output logic [LW-1:0] cmdLevel
);
  logic [2:0] prioCode;
  assign prioCode = wrData[7:5];

  always_comb begin
    if (addr)          rdData = maskReg;
    else if (pollPend) rdData = pollData;
    else if (readIsr)  rdData = svcVec;
    else               rdData = reqVec;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskReg      <= '0;
      vecBase      <= '0;
      autoEoi      <= 1'b0;
      nestedMode   <= 1'b0;
      specMask     <= 1'b0;
      readIsr      <= 1'b0;
      pollPend     <= 1'b0;
      rotateOnAeoi <= 1'b0;
      initClear    <= 1'b0;
      pollAck      <= 1'b0;
      eoiStb       <= 1'b0;
      eoiSpecific  <= 1'b0;
      rotateStb    <= 1'b0;
      setPrioStb   <= 1'b0;
      cmdLevel     <= '0;
    end else begin
      initClear   <= cmd.initStart;
      pollAck     <= cmd.pollRead;
      eoiStb      <= 1'b0;
      eoiSpecific <= 1'b0;
      rotateStb   <= 1'b0;
      setPrioStb  <= 1'b0;
      if (cmd.initStart) begin
        maskReg      <= '0;
        specMask     <= 1'b0;
        readIsr      <= 1'b0;
        pollPend     <= 1'b0;
        autoEoi      <= 1'b0;
        nestedMode   <= 1'b0;
        rotateOnAeoi <= 1'b0;
      end
      if (cmd.loadBase) vecBase <= {wrData[DW-1:3], 3'b000};
      if (cmd.loadMode) begin
        nestedMode <= wrData[4];
        autoEoi    <= wrData[1];
      end
      if (cmd.loadMask) maskReg <= wrData;
      if (cmd.pollRead) pollPend <= 1'b0;
      if (cmd.loadRdCtl) begin
        pollPend <= wrData[2];
        if (wrData[1]) readIsr  <= wrData[0];
        if (wrData[6]) specMask <= wrData[5];
      end
      if (cmd.loadPrio) begin
        cmdLevel <= wrData[LW-1:0];
        unique case (prioCode)
          3'd0, 3'd4: rotateOnAeoi <= prioCode[2];
          3'd1: eoiStb <= 1'b1;
          3'd3: begin eoiStb <= 1'b1; eoiSpecific <= 1'b1; end
          3'd5: begin eoiStb <= 1'b1; rotateStb <= 1'b1; end
          3'd7: begin eoiStb <= 1'b1; eoiSpecific <= 1'b1; rotateStb <= 1'b1; end
          3'd6: setPrioStb <= 1'b1;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/intc_cmd_seq.sv
module intc_cmd_seq
  import intc_cmd_seq_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         wrEn,
  input  logic         rdEn,
  input  logic         addr,
  input  logic [7:0]   wrData,
  output logic [7:0]   rdData,
  input  logic [7:0]   reqVec,
  input  logic [7:0]   svcVec,
  input  logic [7:0]   pollData,
  output logic [7:0]   maskReg,
  output logic [7:0]   vecBase,
  output logic         singleMode,
  output logic         autoEoi,
  output logic         nestedMode,
  output logic         specMask,
  output logic         readIsr,
  output logic         pollPend,
  output logic         rotateOnAeoi,
  output logic         initBusy,
  output logic         initError,
  output logic         initClear,
  output logic         pollAck,
  output logic         eoiStb,
  output logic         eoiSpecific,
  output logic         rotateStb,
  output logic         setPrioStb,
  output logic [2:0]   cmdLevel
);
  seqCmd_t seqCmd;

  intc_cmd_seq_ctrl #(.DW(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .pollPend(pollPend), .cmd(seqCmd),
    .singleMode(singleMode), .initBusy(initBusy), .initError(initError)
  );

  intc_cmd_seq_regs #(.DW(DATA_W), .LW(LVL_W)) u_regs (
    .clk(clk), .rstN(rstN), .cmd(seqCmd), .addr(addr), .wrData(wrData),
    .reqVec(reqVec), .svcVec(svcVec), .pollData(pollData), .rdData(rdData),
    .maskReg(maskReg), .vecBase(vecBase), .autoEoi(autoEoi),
    .nestedMode(nestedMode), .specMask(specMask), .readIsr(readIsr),
    .pollPend(pollPend), .rotateOnAeoi(rotateOnAeoi), .initClear(initClear),
    .pollAck(pollAck), .eoiStb(eoiStb), .eoiSpecific(eoiSpecific),
    .rotateStb(rotateStb), .setPrioStb(setPrioStb), .cmdLevel(cmdLevel)
  );
endmodule

// File: rtl/intc_cmd_seq_chk.sv
module intc_cmd_seq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic       rdEn,
  input logic       addr,
  input logic [7:0] wrData,
  input logic [7:0] maskReg,
  input logic       specMask,
  input logic       readIsr,
  input logic       pollPend,
  input logic       pollAck,
  input logic       initBusy,
  input logic       initError,
  input logic       eoiStb,
  input logic       rotateStb,
  input logic       setPrioStb
);
  AST_INIT_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !addr && wrData[4]) |=> (maskReg == 8'h00 && !specMask && !readIsr)); // R2

  AST_INIT_MASK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr && initBusy) |=> $stable(maskReg)); // R4

  AST_POLL_ONE_READ: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !addr && pollPend && !wrEn) |=> (!pollPend && pollAck)); // R9

  AST_ROTATE_WITH_EOI: assert property (@(posedge clk) disable iff (!rstN)
    rotateStb |-> eoiStb); // R10

  AST_SETPRIO_NO_EOI: assert property (@(posedge clk) disable iff (!rstN)
    !(setPrioStb && eoiStb)); // R11

  AST_ERROR_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !addr && wrData[4]) |=> (initError == $past(wrData[3]))); // R13
endmodule

bind intc_cmd_seq intc_cmd_seq_chk u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
  .wrData(wrData), .maskReg(maskReg), .specMask(specMask), .readIsr(readIsr),
  .pollPend(pollPend), .pollAck(pollAck), .initBusy(initBusy),
  .initError(initError), .eoiStb(eoiStb), .rotateStb(rotateStb),
  .setPrioStb(setPrioStb)
);

// File: tb/intc_cmd_seq_bench.sv
module intc_cmd_seq_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0, rdEn = 1'b0, addr = 1'b0;
  logic [7:0] wrData = '0, reqVec = 8'h81, svcVec = 8'h24, pollData = 8'h83;
  logic [7:0] rdData, maskReg, vecBase;
  logic singleMode, autoEoi, nestedMode, specMask, readIsr, pollPend;
  logic rotateOnAeoi, initBusy, initError, initClear, pollAck;
  logic eoiStb, eoiSpecific, rotateStb, setPrioStb;
  logic [2:0] cmdLevel;
  int nChecks = 0, nFails = 0;

  always #5 clk = ~clk;

  intc_cmd_seq u_intc_cmd_seq (.*);

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] v);
    @(negedge clk); rdEn = 1'b1; addr = a; #1 v = rdData;
    @(negedge clk); rdEn = 1'b0;
  endtask

  function automatic int stb();
    return {eoiStb, eoiSpecific, rotateStb, setPrioStb};
  endfunction

  task automatic t_reset();
    chk("R1 mask", maskReg, 0); chk("R1 base", vecBase, 0);
    chk("R1 flags", {singleMode, autoEoi, nestedMode, specMask, readIsr,
        pollPend, rotateOnAeoi, initBusy, initError, initClear, pollAck}, 0);
    chk("R1 strobes", stb(), 0);
  endtask

  task automatic t_full_init();
    logic [7:0] v;
    wr(1, 8'hAA); wr(0, 8'h68); wr(0, 8'h0B); wr(0, 8'h80);
    wr(0, 8'h11);
    chk("R2 busy", initBusy, 1); chk("R2 mask clear", maskReg, 0);
    chk("R2 flags clear", {specMask, readIsr, rotateOnAeoi}, 0);
    chk("R2 initClear", initClear, 1); chk("R2 single", singleMode, 0);
    @(negedge clk); chk("R2 initClear pulse", initClear, 0);
    wr(1, 8'h47); chk("R3 base", vecBase, 8'h40);
    wr(1, 8'h04); chk("R4 casc busy", initBusy, 1); chk("R4 casc mask", maskReg, 0);
    wr(1, 8'h12); chk("R5 modes", {nestedMode, autoEoi}, 2'b11); chk("R5 done", initBusy, 0);
    wr(1, 8'h5A); chk("R6 mask", maskReg, 8'h5A);
    rd(1, v); chk("R6 read mask", v, 8'h5A);
  endtask

  task automatic t_single_init();
    wr(0, 8'h12); chk("R2 single", singleMode, 1); chk("R5 aeoi cleared", autoEoi, 0);
    wr(1, 8'h28); chk("R3 base", vecBase, 8'h28); chk("R4 single no icw4 done", initBusy, 0);
    wr(1, 8'h33); chk("R6 mask", maskReg, 8'h33);
  endtask

  task automatic t_casc_no_mode();
    wr(0, 8'h10); wr(1, 8'h80); chk("R4 casc next", initBusy, 1);
    wr(1, 8'hFF); chk("R4 done after casc", initBusy, 0); chk("R4 mask held", maskReg, 0);
    wr(1, 8'h0F); chk("R6 mask", maskReg, 8'h0F);
  endtask

  task automatic t_single_mode_word();
    wr(0, 8'h13); wr(1, 8'h08); chk("R4 mode step", initBusy, 1);
    wr(1, 8'h02); chk("R5 aeoi only", {nestedMode, autoEoi}, 2'b01);
    chk("R5 done", initBusy, 0); chk("R4 mask held", maskReg, 0);
  endtask

  task automatic t_error();
    wr(0, 8'h18); chk("R13 error set", initError, 1);
    wr(1, 8'h00); wr(1, 8'h00); chk("R13 error held", initError, 1);
    wr(0, 8'h10); chk("R13 error cleared", initError, 0);
    wr(1, 8'h00); wr(1, 8'h00);
  endtask

  task automatic t_read_ctl();
    logic [7:0] v;
    wr(0, 8'h0B); rd(0, v); chk("R7 isr read", v, 8'h24);
    wr(0, 8'h09); rd(0, v); chk("R7 select held", v, 8'h24);
    wr(0, 8'h0A); rd(0, v); chk("R7 irr read", v, 8'h81);
    wr(0, 8'h68); chk("R8 smm set", specMask, 1);
    wr(0, 8'h28); chk("R8 smm held", specMask, 1);
    wr(0, 8'h48); chk("R8 smm clear", specMask, 0);
  endtask

  task automatic t_poll();
    logic [7:0] v;
    wr(0, 8'h0C); chk("R9 pending", pollPend, 1);
    rd(0, v); chk("R9 poll data", v, 8'h83); chk("R9 ack", pollAck, 1);
    chk("R9 cleared", pollPend, 0);
    rd(0, v); chk("R9 second read", v, 8'h81); chk("R9 ack once", pollAck, 0);
  endtask

  task automatic t_prio();
    wr(0, 8'h20); chk("R10 ns eoi", stb(), 4'b1000);
    @(negedge clk); chk("R10 one cycle", stb(), 0);
    wr(0, 8'h65); chk("R10 spec eoi", stb(), 4'b1100); chk("R10 level", cmdLevel, 5);
    wr(0, 8'hA0); chk("R10 rot eoi", stb(), 4'b1010);
    wr(0, 8'hE6); chk("R10 rot spec eoi", stb(), 4'b1110); chk("R10 level", cmdLevel, 6);
    wr(0, 8'hC3); chk("R11 set prio", stb(), 4'b0001); chk("R11 level", cmdLevel, 3);
    wr(0, 8'h80); chk("R12 raeoi set", rotateOnAeoi, 1); chk("R12 no strobe", stb(), 0);
    wr(0, 8'h40); chk("R12 code2 strobe", stb(), 0); chk("R12 code2 flag", rotateOnAeoi, 1);
    wr(0, 8'h00); chk("R12 raeoi clear", rotateOnAeoi, 0);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    t_full_init();
    t_single_init();
    t_casc_no_mode();
    t_single_mode_word();
    t_error();
    t_read_ctl();
    t_poll();
    t_prio();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    #200000;
    nChecks++; nFails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule